// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table from memory. A client hands over an address and a read/write flag. The block latches the table root from its directory-base input and reads the first-level entry over a single-outstanding memory read port. If that entry is usable, it reads the second-level entry. It then checks that the page is present and that the access is allowed, and returns one of three results: the physical address with the page attributes, a page fault, or a bus error.

The address splits into three fields. The top ten bits index the first-level table. The next ten bits index the second-level table. The low twelve bits are the byte offset within a 4 KiB page. Entries are four bytes wide, so one first-level entry spans 4 MiB of virtual space.

Each response also returns the faulting virtual address and the access direction, so the client has a complete fault record without any extra state. Only one walk runs at a time. A new request is accepted only after the previous response has been taken.

Top module: `xlat_walker`

## Requirements
- R1: The first memory read of a walk goes to `dir_base + 4 * vaddr[31:22]` (32-bit wrap-around).
- R2: The second memory read goes to `(L1 entry with bit 0 cleared) + 4 * vaddr[21:12]`.
- R3: On success `rsp_cause` is 0 and `rsp_paddr` equals `{L2 entry[31:12], vaddr[11:0]}`.
- R4: A first-level entry with bit 0 (present) clear gives `rsp_cause` 1 (page fault). No second read is issued.
- R5: A second-level entry with bit 0 clear gives `rsp_cause` 1.
- R6: Second-level bit 1 grants read and bit 2 grants write. A read with bit 1 clear, or a write with bit 2 clear, gives `rsp_cause` 1. A write with bit 2 set succeeds even when bit 1 is clear.
- R7: `mem_rsp_err` on either read gives `rsp_cause` 2 (bus error), distinct from a page fault. An error on the first read ends the walk with no second read. Cause code 3 is never produced.
- R8: Every response carries the request's virtual address on `rsp_vaddr` and its direction on `rsp_write`.
- R9: The block handles one walk at a time:
  - `req_ready` stays low from acceptance until the response is consumed, and returns high in the cycle after consumption.
  - A memory request keeps its valid and address until `mem_req_ready`.
  - A response keeps its valid and fields until `rsp_ready`.
- R10: On success `rsp_attr` equals bits 8:3 of the second-level entry.
- R11: After reset `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 32 | Physical base of the first-level table, latched at acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry value |
| mem_rsp_err | input | 1 | Read ended in a bus error |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Client takes the result |
| rsp_cause | output | 2 | 0 success, 1 page fault, 2 bus error |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_attr | output | 6 | Cache and allocate attribute bits of the page |
| rsp_vaddr | output | 32 | Virtual address of the walk |
| rsp_write | output | 1 | Direction of the walk |

## Verification
The hardest cases to reach are the early terminations. A first-level fault or first-level bus error must end the walk after exactly one memory read, with no stray second fetch. The bench shows this by counting every read its memory model accepts and comparing that count with the count the requirements predict.

The permission asymmetry also needs care: a write-only page must let a write through while faulting a read. The bench sends both directions against the same second-level entry.

Handshake stability is reached by inserting delays before `mem_req_ready`, before the read data returns, and before `rsp_ready`. Each of these opens a window in which the held values are compared cycle by cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Result codes returned on rsp_cause
  typedef enum logic [1:0] {
    CAUSE_OK     = 2'd0,
    CAUSE_PGFLT  = 2'd1,
    CAUSE_BUSERR = 2'd2
  } cause_e;

  // Walk sequencer states
  typedef enum logic [3:0] {
    S_IDLE,
    S_L1_ADDR,
    S_L1_REQ,
    S_L1_RESP,
    S_L2_ADDR,
    S_L2_REQ,
    S_L2_RESP,
    S_RESP
  } walk_st_e;

  // Entry flag positions (decoded by neighbours, so fixed)
  localparam int BIT_PRESENT = 0;
  localparam int BIT_RD      = 1;
  localparam int BIT_WR      = 2;
  localparam int ATTR_LO     = 3;
  localparam int ATTR_HI     = 8;
  localparam int ATTR_W      = ATTR_HI - ATTR_LO + 1;

endpackage

// File: rtl/xlat_index.sv
// Forms the byte addresses of the two table entries of a walk.
module xlat_index #(
  parameter int ADDR_W   = 32,
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int ENT_LG   = 2
) (
  input  logic [ADDR_W-OFF_BITS-1:0] vpn,
  input  logic [ADDR_W-1:0]          root_base,
  input  logic [ADDR_W-1:0]          leaf_base,
  output logic [ADDR_W-1:0]          l1_addr,
  output logic [ADDR_W-1:0]          l2_addr
);
  localparam int VPN_W = L1_BITS + L2_BITS;
  localparam int PAD1  = ADDR_W - L1_BITS - ENT_LG;
  localparam int PAD2  = ADDR_W - L2_BITS - ENT_LG;

  logic [L1_BITS-1:0] l1_idx;
  logic [L2_BITS-1:0] l2_idx;

  always_comb begin
    l1_idx  = vpn[VPN_W-1:L2_BITS];
    l2_idx  = vpn[L2_BITS-1:0];
    l1_addr = root_base + {{PAD1{1'b0}}, l1_idx, {ENT_LG{1'b0}}};
    l2_addr = leaf_base + {{PAD2{1'b0}}, l2_idx, {ENT_LG{1'b0}}};
  end
endmodule

// File: rtl/xlat_decode.sv
// Splits a fetched table entry into flags, bases and attributes.
module xlat_decode
  import xlat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 12
) (
  input  logic [ADDR_W-1:0] entry,
  input  logic              is_write,
  output logic              present,
  output logic              perm_ok,
  output logic [ADDR_W-1:0] next_base,
  output logic [ADDR_W-OFF_BITS-1:0] page_frame,
  output logic [ATTR_W-1:0] attr
);
  always_comb begin
    present    = entry[BIT_PRESENT];
    perm_ok    = is_write ? entry[BIT_WR] : entry[BIT_RD];
    next_base  = {entry[ADDR_W-1:1], 1'b0};
    page_frame = entry[ADDR_W-1:OFF_BITS];
    attr       = entry[ATTR_HI:ATTR_LO];
  end
endmodule

// File: rtl/xlat_seq.sv
// Walk sequencer: handshakes, latched request and registered outputs.
module xlat_seq
  import xlat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              req_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic              ent_present,
  input  logic              ent_perm_ok,
  input  logic [ADDR_W-1:0] ent_next_base,
  input  logic [ADDR_W-OFF_BITS-1:0] ent_frame,
  input  logic [ATTR_W-1:0] ent_attr,
  input  logic [ADDR_W-1:0] l1_addr,
  input  logic [ADDR_W-1:0] l2_addr,
  output logic [ADDR_W-1:0] va_q,
  output logic              wr_q,
  output logic [ADDR_W-1:0] root_q,
  output logic [ADDR_W-1:0] leaf_q,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output cause_e            rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ATTR_W-1:0] rsp_attr
);
  walk_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      req_ready     <= 1'b1;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      va_q          <= '0;
      wr_q          <= 1'b0;
      root_q        <= '0;
      leaf_q        <= '0;
      rsp_valid     <= 1'b0;
      rsp_cause     <= CAUSE_OK;
      rsp_paddr     <= '0;
      rsp_attr      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            va_q      <= req_vaddr;
            wr_q      <= req_write;
            root_q    <= dir_base;
            req_ready <= 1'b0;
            st        <= S_L1_ADDR;
          end
        end
        S_L1_ADDR: begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= l1_addr;
          st            <= S_L1_REQ;
        end
        S_L2_ADDR: begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= l2_addr;
          st            <= S_L2_REQ;
        end
        S_L1_REQ, S_L2_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st <= (st == S_L1_REQ) ? S_L1_RESP : S_L2_RESP;
          end
        end
        S_L1_RESP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err || !ent_present) begin
              rsp_valid <= 1'b1;
              rsp_cause <= mem_rsp_err ? CAUSE_BUSERR : CAUSE_PGFLT;
              rsp_paddr <= '0;
              rsp_attr  <= '0;
              st        <= S_RESP;
            end else begin
              leaf_q <= ent_next_base;
              st     <= S_L2_ADDR;
            end
          end
        end
        S_L2_RESP: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            st        <= S_RESP;
            if (mem_rsp_err) begin
              rsp_cause <= CAUSE_BUSERR;
              rsp_paddr <= '0;
              rsp_attr  <= '0;
            end else if (!ent_present || !ent_perm_ok) begin
              rsp_cause <= CAUSE_PGFLT;
              rsp_paddr <= '0;
              rsp_attr  <= '0;
            end else begin
              rsp_cause <= CAUSE_OK;
              rsp_paddr <= {ent_frame, va_q[OFF_BITS-1:0]};
              rsp_attr  <= ent_attr;
            end
          end
        end
        S_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            req_ready <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker.sv
// Top: two-level table walker with one walk in flight.
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int ENT_LG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic [ADDR_W-1:0] rsp_vaddr,
  output logic              rsp_write
);
  localparam int VPN_W = ADDR_W - OFF_BITS;

  logic [ADDR_W-1:0] va_q, root_q, leaf_q, l1_addr, l2_addr, next_base;
  logic              wr_q, present, perm_ok;
  logic [VPN_W-1:0]  frame;
  logic [ATTR_W-1:0] attr;
  cause_e            cause;

  xlat_index #(
    .ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
    .OFF_BITS(OFF_BITS), .ENT_LG(ENT_LG)
  ) u_index (
    .vpn(va_q[ADDR_W-1:OFF_BITS]),
    .root_base(root_q),
    .leaf_base(leaf_q),
    .l1_addr(l1_addr),
    .l2_addr(l2_addr)
  );

  xlat_decode #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS)) u_decode (
    .entry(mem_rsp_data),
    .is_write(wr_q),
    .present(present),
    .perm_ok(perm_ok),
    .next_base(next_base),
    .page_frame(frame),
    .attr(attr)
  );

  xlat_seq #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .dir_base(dir_base), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .ent_present(present), .ent_perm_ok(perm_ok),
    .ent_next_base(next_base), .ent_frame(frame), .ent_attr(attr),
    .l1_addr(l1_addr), .l2_addr(l2_addr),
    .va_q(va_q), .wr_q(wr_q), .root_q(root_q), .leaf_q(leaf_q),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_cause(cause), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr)
  );

  assign rsp_cause = cause;
  assign rsp_vaddr = va_q;
  assign rsp_write = wr_q;
endmodule

// File: rtl/xlat_walker_chk.sv
// Protocol checker attached to the walker.
module xlat_walker_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] rsp_vaddr
);
  // R9: memory request held until accepted
  a_r9_mreq_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9: response held until consumed
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_cause) && $stable(rsp_vaddr));

  // R9: idle means nothing outstanding
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid && !rsp_valid);

  // R9: ready returns after consumption
  a_r9_ready_back: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready |=> req_ready);

  // R3: page offset passes through on success
  a_r3_offset: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_cause == 2'd0 |->
      rsp_paddr[OFF_BITS-1:0] == rsp_vaddr[OFF_BITS-1:0]);

  // R7: only defined cause codes
  a_r7_cause_legal: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_cause != 2'd3);
endmodule

bind xlat_walker xlat_walker_chk #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
);

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dir_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        mem_rsp_err;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic [5:0]  rsp_attr;
  logic [31:0] rsp_vaddr;
  logic        rsp_write;

  int checks = 0;
  int failures = 0;

  // memory model configuration
  logic [31:0] l1_word, l2_word;
  bit          l1_err, l2_err;
  int          rdy_dly = 0, rsp_dly = 0;
  int          fetch_n = 0;
  logic [31:0] obs_addr [4];

  always #4 clk = ~clk;

  xlat_walker u0 (
    .clk(clk), .rst(rst), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
    .rsp_vaddr(rsp_vaddr), .rsp_write(rsp_write)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory read responder: first fetch answers l1_word, second l2_word
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    mem_rsp_err   = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (rdy_dly) @(negedge clk);
        if (fetch_n < 4) obs_addr[fetch_n] = mem_req_addr;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = (fetch_n == 0) ? l1_word : l2_word;
        mem_rsp_err   = (fetch_n == 0) ? l1_err : l2_err;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        fetch_n++;
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] base,
                     input logic [31:0] va, input bit wr,
                     input logic [31:0] e1, input bit er1,
                     input logic [31:0] e2, input bit er2, input int hold);
    logic [31:0] a1, a2, pa_exp, pa_seen;
    logic [1:0]  c_exp, c_seen;
    int          f_exp, n;
    // expected outcome from the requirements
    a1 = base + {20'b0, va[31:22], 2'b00};
    a2 = {e1[31:1], 1'b0} + {20'b0, va[21:12], 2'b00};
    pa_exp = '0;
    if (er1) begin c_exp = 2'd2; f_exp = 1; end
    else if (!e1[0]) begin c_exp = 2'd1; f_exp = 1; end
    else begin
      f_exp = 2;
      if (er2) c_exp = 2'd2;
      else if (!e2[0] || (wr ? !e2[2] : !e2[1])) c_exp = 2'd1;
      else begin c_exp = 2'd0; pa_exp = {e2[31:12], va[11:0]}; end
    end
    l1_word = e1; l1_err = er1; l2_word = e2; l2_err = er2;
    fetch_n = 0;
    @(negedge clk);
    dir_base = base; req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; dir_base = 32'hDEAD_0000;
    chk(req_ready == 1'b0, {"R9 busy after accept ", tag}, {31'b0, req_ready}, 0);
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    chk(rsp_valid == 1'b1, {"R9 response arrives ", tag}, {31'b0, rsp_valid}, 1);
    chk(rsp_cause == c_exp, {tag, " cause"}, {30'b0, rsp_cause}, {30'b0, c_exp});
    chk(rsp_vaddr == va, {"R8 vaddr ", tag}, rsp_vaddr, va);
    chk(rsp_write == wr, {"R8 write flag ", tag}, {31'b0, rsp_write}, {31'b0, wr});
    if (c_exp == 2'd0) begin
      chk(rsp_paddr == pa_exp, {"R3 paddr ", tag}, rsp_paddr, pa_exp);
      chk(rsp_attr == e2[8:3], {"R10 attr ", tag}, {26'b0, rsp_attr}, {26'b0, e2[8:3]});
    end
    pa_seen = rsp_paddr; c_seen = rsp_cause;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa_seen && rsp_cause == c_seen && !req_ready,
          {"R9 hold response ", tag}, rsp_paddr, pa_seen);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, {"R9 ready after consume ", tag},
        {30'b0, rsp_valid, req_ready}, 32'h1);
    chk(fetch_n == f_exp, {"R4 R7 fetch count ", tag}, fetch_n, f_exp);
    chk(obs_addr[0] == a1, {"R1 L1 address ", tag}, obs_addr[0], a1);
    if (f_exp == 2)
      chk(obs_addr[1] == a2, {"R2 L2 address ", tag}, obs_addr[1], a2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset req_ready", {31'b0, req_ready}, 1);
    chk(!mem_req_valid && !rsp_valid, "R11 reset valids",
        {30'b0, mem_req_valid, rsp_valid}, 0);

    run("R3 read ok",        32'h8000_0000, 32'h1234_5678, 0, 32'h0040_0001, 0, 32'hABCD_E153, 0, 0);
    run("R6 write-only ok",  32'h8000_0000, 32'h0040_1ABC, 1, 32'h0040_0001, 0, 32'h0000_5005, 0, 0);
    run("R6 read denied",    32'h8000_0000, 32'h0040_1ABC, 0, 32'h0040_0001, 0, 32'h0000_5005, 0, 0);
    run("R6 write denied",   32'h8000_0000, 32'h0040_1ABC, 1, 32'h0040_0001, 0, 32'h0000_5003, 0, 0);
    run("R4 L1 absent",      32'h8000_0000, 32'h1234_5678, 0, 32'h0040_0000, 0, 32'hABCD_E153, 0, 0);
    run("R5 L2 absent",      32'h8000_0000, 32'h1234_5678, 1, 32'h0040_0001, 0, 32'hABCD_E006, 0, 0);
    run("R7 L1 bus error",   32'h8000_0000, 32'h1234_5678, 0, 32'h0040_0001, 1, 32'hABCD_E153, 0, 0);
    run("R7 L2 bus error",   32'h8000_0000, 32'h1234_5678, 0, 32'h0040_0001, 0, 32'hABCD_E153, 1, 0);
    rdy_dly = 2; rsp_dly = 3;
    run("R9 stalls",         32'h0010_0000, 32'h7654_3210, 1, 32'h0020_0001, 0, 32'h1111_1007, 0, 3);
    rdy_dly = 0; rsp_dly = 1;
    run("R1 top index",      32'h1000_0000, 32'hFFFF_FFFF, 1, 32'h0000_3FFF, 0, 32'hFFFF_F1FF, 0, 1);
    run("R2 zero address",   32'h0000_0000, 32'h0000_0000, 0, 32'h0000_0001, 0, 32'h0000_0003, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule